// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host a narrow, 64-bit CSR window onto a 32-bit internal register bus. The host does not map the internal registers directly. It writes one command word to the control register, and that word carries an opcode, a 13-bit internal word address and 32 bits of write data. The bridge then runs exactly one transfer on the internal bus using a request/acknowledge handshake.

When the transfer is acknowledged, the bridge sets a valid flag in its status register. For a read, the status register also returns the data. The host polls this flag instead of being held in a bus wait state. A transfer that is never acknowledged leaves the flag low, so the host's own poll limit decides when to give up.

A read-only parameter register describes the serial controller that sits behind the internal bus. Its content is fixed by parameters at build time.

Top module: `idxb_bridge`

## Requirements
- R1: While `rst` is high and on the cycle after it, `ib_req` is 0, the status valid flag is 0 and the status data field is 0.
- R2: A host read of offset 0x08 returns the parameter word:
  - bit 1 is the shift order (1 = LSB first);
  - bits 7:2 are the word width;
  - bits 13:8 are the chip-select count;
  - bit 14 is the clock polarity;
  - bit 15 is the clock phase;
  - bits 47:32 are the peripheral ID;
  - all other bits are 0.
  A host write to 0x08 does not change this word.
- R3: A host write to the control offset 0x10 carries the command code in bits 63:62 (1 = read, 2 = write), the internal address in bits 44:32 and the write data in bits 31:0. On the clock edge that accepts it, the bridge drives `ib_req` = 1, `ib_addr`, `ib_wdata` and `ib_we` (1 only for a write).
- R4: `ib_req`, `ib_addr`, `ib_we` and `ib_wdata` hold steady until `ib_ack` is sampled high. `ib_req` drops on the following cycle, so each command makes exactly one transfer.
- R5: The valid flag is bit 32 of the status register at offset 0x18. It is cleared when a read or write command is accepted. It becomes 1 on the cycle after `ib_ack` is sampled with `ib_req` high.
- R6: The status data field (bits 31:0) captures `ib_rdata` when a read completes. It changes at no other time outside reset; in particular, a completed write leaves it unchanged.
- R7: Command codes 0 (no operation) and 3 (reserved) start no transfer and leave the whole status register unchanged.
- R8: A control write that arrives while a transfer is outstanding is ignored. The outstanding transfer's address and data stay unchanged, and no second transfer follows.
- R9: If `ib_ack` never arrives, `ib_req` stays high and the valid flag stays 0 for as long as the host keeps polling.
- R10: Host reads of the control offset, or of any unmapped offset, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wen | input | 1 | Host write strobe |
| csr_waddr | input | 6 | Host write byte offset |
| csr_wdata | input | 64 | Host write data |
| csr_raddr | input | 6 | Host read byte offset |
| csr_rdata | output | 64 | Host read data (combinational) |
| ib_req | output | 1 | Internal bus transfer request |
| ib_we | output | 1 | Internal bus write enable |
| ib_addr | output | 13 | Internal bus word address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 32 | Internal bus read data, valid with ib_ack |

## Verification
The bound checker watches the internal-bus handshake on every cycle:
- request, address and data held steady until the acknowledge, and the request dropped right after it;
- the valid flag low while a request is open and high on the cycle after the acknowledge;
- the status data frozen except when a read completes;
- the reset state.

Some behaviours are visible only through the bench's host-side scenarios, which decode the command word and compare the status register with independently tracked values:
- the field positions in the command and parameter words;
- a no-operation or reserved code leaving the status register untouched;
- a command dropped while the bridge is busy;
- a transfer that is never acknowledged.

// File: rtl/idxb_pkg.sv
package idxb_pkg;

    localparam int HOST_AW = 6;
    localparam int IB_AW   = 13;
    localparam int IB_DW   = 32;

    localparam logic [HOST_AW-1:0] OFS_PARAM = 6'h08;
    localparam logic [HOST_AW-1:0] OFS_CTRL  = 6'h10;
    localparam logic [HOST_AW-1:0] OFS_STAT  = 6'h18;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } bus_cmd_e;

    typedef struct packed {
        bus_cmd_e          cmd;
        logic [IB_AW-1:0]  addr;
        logic [IB_DW-1:0]  wdata;
    } bus_op_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_e;

    function automatic bus_op_t unpack_ctrl(input logic [63:0] w);
        bus_op_t o;
        o.cmd   = bus_cmd_e'(w[63:62]);
        o.addr  = w[44:32];
        o.wdata = w[31:0];
        return o;
    endfunction

    function automatic logic [63:0] pack_status(input logic v, input logic [IB_DW-1:0] d);
        logic [63:0] s;
        s        = '0;
        s[31:0]  = d;
        s[32]    = v;
        return s;
    endfunction

    function automatic logic [63:0] pack_param(input logic lsb_first,
                                               input logic [5:0] word_bits,
                                               input logic [5:0] cs_count,
                                               input logic cpol,
                                               input logic cpha,
                                               input logic [15:0] periph_id);
        logic [63:0] p;
        p        = '0;
        p[1]     = lsb_first;
        p[7:2]   = word_bits;
        p[13:8]  = cs_count;
        p[14]    = cpol;
        p[15]    = cpha;
        p[47:32] = periph_id;
        return p;
    endfunction

endpackage

// File: rtl/idxb_csr_decode.sv
module idxb_csr_decode
    import idxb_pkg::*;
(
    input  logic                csr_wen,
    input  logic [HOST_AW-1:0]  csr_waddr,
    input  logic [63:0]         csr_wdata,
    input  logic [HOST_AW-1:0]  csr_raddr,
    input  logic [63:0]         param_word,
    input  logic [63:0]         status_word,
    output logic                cmd_start,
    output bus_op_t             cmd_op,
    output logic [63:0]         csr_rdata
);

    always_comb begin
        cmd_op    = unpack_ctrl(csr_wdata);
        cmd_start = csr_wen && (csr_waddr == OFS_CTRL) &&
                    ((cmd_op.cmd == CMD_READ) || (cmd_op.cmd == CMD_WRITE));
    end

    always_comb begin
        case (csr_raddr)
            OFS_PARAM: csr_rdata = param_word;
            OFS_STAT:  csr_rdata = status_word;
            default:   csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/idxb_bus_engine.sv
module idxb_bus_engine
    import idxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  bus_op_t           cmd_op,
    output logic              ib_req,
    output logic              ib_we,
    output logic [IB_AW-1:0]  ib_addr,
    output logic [IB_DW-1:0]  ib_wdata,
    input  logic              ib_ack,
    input  logic [IB_DW-1:0]  ib_rdata,
    output logic              sts_valid,
    output logic [IB_DW-1:0]  sts_data
);

    eng_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            ib_req    <= 1'b0;
            ib_we     <= 1'b0;
            ib_addr   <= '0;
            ib_wdata  <= '0;
            sts_valid <= 1'b0;
            sts_data  <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (cmd_start) begin
                        state     <= ENG_BUSY;
                        ib_req    <= 1'b1;
                        ib_we     <= (cmd_op.cmd == CMD_WRITE);
                        ib_addr   <= cmd_op.addr;
                        ib_wdata  <= cmd_op.wdata;
                        sts_valid <= 1'b0;
                    end
                end
                ENG_BUSY: begin
                    if (ib_ack) begin
                        state     <= ENG_IDLE;
                        ib_req    <= 1'b0;
                        sts_valid <= 1'b1;
                        if (!ib_we) begin
                            sts_data <= ib_rdata;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/idxb_bridge.sv
module idxb_bridge
    import idxb_pkg::*;
#(
    parameter logic        SHIFT_LSB = 1'b0,
    parameter int          WORD_BITS = 32,
    parameter int          CS_COUNT  = 1,
    parameter logic        CLK_POL   = 1'b0,
    parameter logic        CLK_PHA   = 1'b0,
    parameter logic [15:0] PERIPH_ID = 16'h00A5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csr_wen,
    input  logic [HOST_AW-1:0]  csr_waddr,
    input  logic [63:0]         csr_wdata,
    input  logic [HOST_AW-1:0]  csr_raddr,
    output logic [63:0]         csr_rdata,
    output logic                ib_req,
    output logic                ib_we,
    output logic [IB_AW-1:0]    ib_addr,
    output logic [IB_DW-1:0]    ib_wdata,
    input  logic                ib_ack,
    input  logic [IB_DW-1:0]    ib_rdata
);

    localparam logic [63:0] PARAM_WORD =
        pack_param(SHIFT_LSB, 6'(WORD_BITS), 6'(CS_COUNT), CLK_POL, CLK_PHA, PERIPH_ID);

    logic              cmd_start;
    bus_op_t           cmd_op;
    logic              sts_valid;
    logic [IB_DW-1:0]  sts_data;
    logic [63:0]       status_word;

    assign status_word = pack_status(sts_valid, sts_data);

    idxb_csr_decode u_dec (
        .csr_wen     (csr_wen),
        .csr_waddr   (csr_waddr),
        .csr_wdata   (csr_wdata),
        .csr_raddr   (csr_raddr),
        .param_word  (PARAM_WORD),
        .status_word (status_word),
        .cmd_start   (cmd_start),
        .cmd_op      (cmd_op),
        .csr_rdata   (csr_rdata)
    );

    idxb_bus_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .ib_req    (ib_req),
        .ib_we     (ib_we),
        .ib_addr   (ib_addr),
        .ib_wdata  (ib_wdata),
        .ib_ack    (ib_ack),
        .ib_rdata  (ib_rdata),
        .sts_valid (sts_valid),
        .sts_data  (sts_data)
    );

endmodule

// File: rtl/idxb_chk.sv
module idxb_chk
    import idxb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ib_req,
    input logic              ib_we,
    input logic [IB_AW-1:0]  ib_addr,
    input logic [IB_DW-1:0]  ib_wdata,
    input logic              ib_ack,
    input logic              sts_valid,
    input logic [IB_DW-1:0]  sts_data
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!ib_req && !sts_valid && (sts_data == '0)));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ack) |=> !ib_req);

    // R5
    valid_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ack) |=> sts_valid);

    // R9
    valid_low_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ib_req |-> !sts_valid);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ib_req && ib_ack && !ib_we) |=> $stable(sts_data));

endmodule

bind idxb_bridge idxb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ib_req    (ib_req),
    .ib_we     (ib_we),
    .ib_addr   (ib_addr),
    .ib_wdata  (ib_wdata),
    .ib_ack    (ib_ack),
    .sts_valid (sts_valid),
    .sts_data  (sts_data)
);

// File: tb/sim_idxb_bridge.sv
module sim_idxb_bridge;
    import idxb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] EXP_PARAM = 64'h0000BEEF_00004342;

    typedef struct packed {
        logic [1:0]  cmd;
        logic [12:0] addr;
        logic [31:0] wd;
        logic [31:0] resp;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 13'h0400, 32'h0000_0000, 32'hCAFE_F00D, 4'd0},
        '{2'd2, 13'h0401, 32'h1234_5678, 32'hDEAD_0000, 4'd1},
        '{2'd1, 13'h1FFF, 32'h0000_0000, 32'hFFFF_FFFF, 4'd3},
        '{2'd2, 13'h0000, 32'hFFFF_FFFF, 32'h5555_5555, 4'd0},
        '{2'd1, 13'h0000, 32'h0000_0000, 32'h0000_0001, 4'd7},
        '{2'd2, 13'h1FFF, 32'hA5A5_A5A5, 32'h0BAD_0BAD, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wen = 1'b0;
    logic [5:0]  csr_waddr = '0;
    logic [63:0] csr_wdata = '0;
    logic [5:0]  csr_raddr = OFS_STAT;
    logic [63:0] csr_rdata;
    logic        ib_req, ib_we;
    logic [12:0] ib_addr;
    logic [31:0] ib_wdata;
    logic        ib_ack = 1'b0;
    logic [31:0] ib_rdata = '0;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_data = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idxb_bridge #(
        .SHIFT_LSB (1'b1),
        .WORD_BITS (16),
        .CS_COUNT  (3),
        .CLK_POL   (1'b1),
        .CLK_PHA   (1'b0),
        .PERIPH_ID (16'hBEEF)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .csr_wen   (csr_wen),
        .csr_waddr (csr_waddr),
        .csr_wdata (csr_wdata),
        .csr_raddr (csr_raddr),
        .csr_rdata (csr_rdata),
        .ib_req    (ib_req),
        .ib_we     (ib_we),
        .ib_addr   (ib_addr),
        .ib_wdata  (ib_wdata),
        .ib_ack    (ib_ack),
        .ib_rdata  (ib_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic host_write(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wen = 1'b1; csr_waddr = a; csr_wdata = d;
        @(negedge clk);
        csr_wen = 1'b0;
    endtask

    function automatic logic [63:0] ctrl_word(input logic [1:0] c, input logic [12:0] a, input logic [31:0] d);
        return {c, 17'b0, a, d};
    endfunction

    task automatic run_op(input logic [1:0] c, input logic [12:0] a, input logic [31:0] wd,
                          input logic [31:0] resp, input int dly);
        host_write(OFS_CTRL, ctrl_word(c, a, wd));
        check("R3 req raised", 64'(ib_req), 64'd1);
        check("R3 addr field", 64'(ib_addr), 64'(a));
        check("R3 we", 64'(ib_we), 64'(c == 2'd2));
        if (c == 2'd2) check("R3 wdata field", 64'(ib_wdata), 64'(wd));
        check("R5 valid cleared", 64'(csr_rdata[32]), 64'd0);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check("R4 req held", 64'(ib_req), 64'd1);
            check("R4 addr held", 64'(ib_addr), 64'(a));
        end
        ib_ack = 1'b1; ib_rdata = resp;
        @(negedge clk);
        ib_ack = 1'b0; ib_rdata = 32'h0;
        if (c == 2'd1) exp_data = resp;
        check("R4 req dropped", 64'(ib_req), 64'd0);
        check("R5 valid set", 64'(csr_rdata[32]), 64'd1);
        check("R6 status data", 64'(csr_rdata[31:0]), 64'(exp_data));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while held in reset
        check("R1 req in reset", 64'(ib_req), 64'd0);
        check("R1 status in reset", csr_rdata, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status after reset", csr_rdata, 64'd0);

        // R2 parameter word and its immunity to writes
        csr_raddr = OFS_PARAM;
        @(negedge clk);
        check("R2 param word", csr_rdata, EXP_PARAM);
        host_write(OFS_PARAM, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R2 param after write", csr_rdata, EXP_PARAM);
        check("R2 no req from param write", 64'(ib_req), 64'd0);
        // R10 control and unmapped offsets read zero
        csr_raddr = OFS_CTRL;
        @(negedge clk);
        check("R10 ctrl reads zero", csr_rdata, 64'd0);
        csr_raddr = 6'h20;
        @(negedge clk);
        check("R10 unmapped reads zero", csr_rdata, 64'd0);
        csr_raddr = OFS_STAT;

        // Vector walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].cmd, VECS[v].addr, VECS[v].wd, VECS[v].resp, int'(VECS[v].dly));
        end

        // R7 no-op and reserved codes leave status untouched
        host_write(OFS_CTRL, ctrl_word(2'd0, 13'h0123, 32'h1111_1111));
        check("R7 nop no req", 64'(ib_req), 64'd0);
        check("R7 nop status", csr_rdata, {31'b0, 1'b1, exp_data});
        host_write(OFS_CTRL, ctrl_word(2'd3, 13'h0456, 32'h2222_2222));
        check("R7 rsvd no req", 64'(ib_req), 64'd0);
        check("R7 rsvd status", csr_rdata, {31'b0, 1'b1, exp_data});

        // R8 command while busy is dropped
        host_write(OFS_CTRL, ctrl_word(2'd1, 13'h0AAA, 32'h0));
        host_write(OFS_CTRL, ctrl_word(2'd2, 13'h0555, 32'h7777_7777));
        check("R8 addr kept", 64'(ib_addr), 64'h0AAA);
        check("R8 still read", 64'(ib_we), 64'd0);
        ib_ack = 1'b1; ib_rdata = 32'h3C3C_3C3C;
        @(negedge clk);
        ib_ack = 1'b0;
        exp_data = 32'h3C3C_3C3C;
        repeat (3) @(negedge clk);
        check("R8 no second transfer", 64'(ib_req), 64'd0);
        check("R8 single completion", csr_rdata, {31'b0, 1'b1, exp_data});

        // R9 stuck access keeps valid low
        host_write(OFS_CTRL, ctrl_word(2'd2, 13'h0042, 32'h9999_0000));
        for (int p = 0; p < 12000; p++) begin
            @(negedge clk);
            if (csr_rdata[32] || !ib_req) begin
                check("R9 stuck poll", {62'b0, ib_req, csr_rdata[32]}, 64'd2);
                break;
            end
        end
        check("R9 valid low after polls", 64'(csr_rdata[32]), 64'd0);
        check("R9 req still high", 64'(ib_req), 64'd1);

        // R1 reset during an outstanding transfer
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_data = '0;
        check("R1 req cleared by reset", 64'(ib_req), 64'd0);
        check("R1 status cleared by reset", csr_rdata, 64'd0);

        // R6 write completion keeps previous data
        run_op(2'd1, 13'h0010, 32'h0, 32'h8765_4321, 1);
        run_op(2'd2, 13'h0011, 32'hFEED_BEEF, 32'h1111_2222, 0);
        check("R6 data after write", 64'(csr_rdata[31:0]), 64'h8765_4321);

        done = 1'b1;
        finish_run();
    end

endmodule